// File: doc/BRIEF.md
# Functional Unit Occupancy Scoreboard

This block decides, one request per cycle, whether an operation may start on a pool of execution units, and then follows it until its result is due. Each operation class has two independent numbers: how many cycles until its result is ready, and how many cycles it keeps its unit occupied. A long-latency class may release its unit well before its result appears. Some classes are cracked sequences whose steps feed each other, so their result latency is the sum of the step latencies.

A requester presents a pool code, a class code, a parity restriction and a tag. The grant is combinational in the same cycle. On a refusal nothing is recorded, and the requester retries later. On a grant, the chosen unit is held busy and one of a fixed number of tracking slots counts the latency down. When the count runs out, that slot raises its bit in the result-ready mask for one cycle and presents the requester's tag.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset every unit and every tracking slot is free. `doneMask` is zero, and `reqGrant` is low while `reqValid` is low.
- R2: Pool codes are 0 integer ALU (4 units), 1 divide (2), 2 floating point (4), 3 decimal/quad (1), 4 load/store (4), 5 permute (2), 6 branch (1) and 7 crypto (1). Global unit numbers run 0..18 in pool-code order: ALU 0-3, divide 4-5, FP 6-9, decimal 10, load/store 11-14, permute 15-16, branch 17, crypto 18.
- R3: A granted class of result latency L, issued in cycle c, raises bit s of `doneMask` in cycle c+L only, where s is its tracking slot. Its tag appears on `doneTags[s*TAG_W +: TAG_W]` in that cycle. A store (pool 4, class 0) has L=1.
- R4: A unit granted an op of busy time B is not granted again before cycle c+B and is eligible again from cycle c+B. The busy times are 1 for ALU, load/store, permute, branch and crypto; divide classes 2-7 have 8; FP classes 2/3/4/5/6/7 have 5/5/8/10/8/10; decimal classes 1..5 have 11, 12, 25, 44 and 62.
- R5: Among the eligible free units of the requested pool, the lowest-numbered one is granted, and `grantUnit` gives its global number (0 when there is no grant).
- R6: `reqParity` is 0 for any unit, 1 for even-only and 2 for odd-only, where parity is the unit's index within its pool. Code 3 is always refused. A one-unit pool has only an even unit.
- R7: Cracked classes have a latency equal to the sum of their steps: ALU class 2 = 4, ALU class 3 = 6; load/store classes 4, 5, 6 and 7 = 6, 7, 8 and 8; divide classes 5, 6 and 7 = 18, 26 and 42; branch class 2 = 7.
- R8: A request is refused in the same cycle if its class is undefined or no eligible unit is free. A refused request never produces a result pulse. Defined classes are ALU 0-3, divide 0-7, FP 0-7, decimal 0-5, load/store 0-7, permute 0, branch 0-2 and crypto 0.
- R9: Single-step latencies are ALU 2/3, divide 5/12/16/24/40 (classes 0-4), FP 5/7/22/26/33/36/24/27 (classes 0-7), decimal 12/23/24/37/58/76 (classes 0-5), load/store 1/4/5/6 (classes 0-3), permute 3, branch 2/5 and crypto 6. Latency runs on independently of unit release.
- R10: A request is refused when all `NUM_SLOTS` tracking slots are in use, even if a unit is free. The lowest-numbered free slot is taken, and a slot whose pulse is in the current cycle may be taken again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Issue request present |
| reqPool | input | 3 | Unit pool code (R2) |
| reqOp | input | 3 | Operation class within the pool |
| reqParity | input | 2 | Parity restriction (R6) |
| reqTag | input | TAG_W | Tag returned with the result pulse |
| reqGrant | output | 1 | Request accepted this cycle |
| grantUnit | output | UNIT_W (5) | Global number of the granted unit |
| doneMask | output | NUM_SLOTS | One bit per tracking slot whose result is ready this cycle |
| doneTags | output | NUM_SLOTS*TAG_W | Tag held by each tracking slot |

## Verification
Two situations are hard to reach from the ports. The first is slot exhaustion while units stay free. The stimulus reaches it by filling every tracking slot with long-latency work spread over the FP, divide and decimal pools, then sending a short load that finds a free unit but no slot. The second is reuse of a slot in the very cycle its pulse leaves, and the follow-up request is timed to land exactly on that cycle. Occupancy edges are reached by retrying a pool one cycle before and exactly at the end of its busy window, including the 62-cycle decimal case.

// File: rtl/fu_scb_pkg.sv
package fu_scb_pkg;

  typedef enum logic [2:0] {
    POOL_ALU, POOL_DIV, POOL_FP, POOL_DEC, POOL_LS, POOL_PERM, POOL_BR, POOL_CRYPTO
  } poolE;

  localparam int ALU_UNITS    = 4;
  localparam int DIV_UNITS    = 2;
  localparam int FP_UNITS     = 4;
  localparam int DEC_UNITS    = 1;
  localparam int LS_UNITS     = 4;
  localparam int PERM_UNITS   = 2;
  localparam int BR_UNITS     = 1;
  localparam int CRYPTO_UNITS = 1;
  localparam int NUM_POOLS    = 8;
  localparam int NUM_UNITS    = ALU_UNITS + DIV_UNITS + FP_UNITS + DEC_UNITS +
                                LS_UNITS + PERM_UNITS + BR_UNITS + CRYPTO_UNITS;
  localparam int UNIT_W       = $clog2(NUM_UNITS);
  localparam int LAT_W        = 7;
  localparam int BUSY_W       = 6;

  typedef struct packed {
    logic              ok;
    logic [LAT_W-1:0]  lat;
    logic [BUSY_W-1:0] busy;
  } opInfoT;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic [NUM_UNITS-1:0] unitHot;
    logic [LAT_W-1:0]     lat;
    logic [BUSY_W-1:0]    busy;
  } issueStrobeT;

  function automatic int poolCount(input logic [2:0] p);
    case (poolE'(p))
      POOL_ALU:  return ALU_UNITS;
      POOL_DIV:  return DIV_UNITS;
      POOL_FP:   return FP_UNITS;
      POOL_DEC:  return DEC_UNITS;
      POOL_LS:   return LS_UNITS;
      POOL_PERM: return PERM_UNITS;
      POOL_BR:   return BR_UNITS;
      default:   return CRYPTO_UNITS;
    endcase
  endfunction

  function automatic int poolBase(input logic [2:0] p);
    int b;
    b = 0;
    for (int i = 0; i < NUM_POOLS; i++)
      if (i < int'(p)) b += poolCount(3'(i));
    return b;
  endfunction

  function automatic opInfoT mkOp(input int l, input int b);
    opInfoT r;
    r.ok   = 1'b1;
    r.lat  = LAT_W'(l);
    r.busy = BUSY_W'(b);
    return r;
  endfunction

  // latency / occupancy per class; cracked classes carry summed latency
  function automatic opInfoT opLookup(input logic [2:0] pool, input logic [2:0] op);
    opInfoT r;
    r = '0;
    case (poolE'(pool))
      POOL_ALU: case (op)
        3'd0: r = mkOp(2, 1);
        3'd1: r = mkOp(3, 1);
        3'd2: r = mkOp(4, 1);
        3'd3: r = mkOp(6, 1);
        default: r = '0;
      endcase
      POOL_DIV: case (op)
        3'd0: r = mkOp(5, 1);
        3'd1: r = mkOp(12, 1);
        3'd2: r = mkOp(16, 8);
        3'd3: r = mkOp(24, 8);
        3'd4: r = mkOp(40, 8);
        3'd5: r = mkOp(18, 8);
        3'd6: r = mkOp(26, 8);
        default: r = mkOp(42, 8);
      endcase
      POOL_FP: case (op)
        3'd0: r = mkOp(5, 1);
        3'd1: r = mkOp(7, 1);
        3'd2: r = mkOp(22, 5);
        3'd3: r = mkOp(26, 5);
        3'd4: r = mkOp(33, 8);
        3'd5: r = mkOp(36, 10);
        3'd6: r = mkOp(24, 8);
        default: r = mkOp(27, 10);
      endcase
      POOL_DEC: case (op)
        3'd0: r = mkOp(12, 1);
        3'd1: r = mkOp(23, 11);
        3'd2: r = mkOp(24, 12);
        3'd3: r = mkOp(37, 25);
        3'd4: r = mkOp(58, 44);
        3'd5: r = mkOp(76, 62);
        default: r = '0;
      endcase
      POOL_LS: case (op)
        3'd0: r = mkOp(1, 1);
        3'd1: r = mkOp(4, 1);
        3'd2: r = mkOp(5, 1);
        3'd3: r = mkOp(6, 1);
        3'd4: r = mkOp(6, 1);
        3'd5: r = mkOp(7, 1);
        default: r = mkOp(8, 1);
      endcase
      POOL_PERM: r = (op == 3'd0) ? mkOp(3, 1) : '0;
      POOL_BR: case (op)
        3'd0: r = mkOp(2, 1);
        3'd1: r = mkOp(5, 1);
        3'd2: r = mkOp(7, 1);
        default: r = '0;
      endcase
      default: r = (op == 3'd0) ? mkOp(6, 1) : '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fu_scb_ctrl.sv
module fu_scb_ctrl
  import fu_scb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 reqValid,
  input  logic [2:0]           reqPool,
  input  logic [2:0]           reqOp,
  input  logic [1:0]           reqParity,
  input  logic [NUM_UNITS-1:0] unitFree,
  input  logic [NUM_SLOTS-1:0] slotFree,
  output issueStrobeT          strobe,
  output logic [NUM_SLOTS-1:0] slotHot,
  output logic                 grant,
  output logic [UNIT_W-1:0]    grantUnit
);

  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  opInfoT               info;
  logic [NUM_UNITS-1:0] eligible;
  logic                 unitFound;
  logic [UNIT_W-1:0]    pickUnit;
  logic                 slotFound;
  logic [SLOT_W-1:0]    pickSlot;
  int                   base;
  int                   cnt;

  always_comb begin
    info = opLookup(reqPool, reqOp);
    base = poolBase(reqPool);
    cnt  = poolCount(reqPool);
    for (int u = 0; u < NUM_UNITS; u++) begin
      logic inPool;
      logic oddIdx;
      logic parOk;
      inPool = (u >= base) && (u < base + cnt);
      oddIdx = ((u - base) % 2) != 0;
      parOk  = (reqParity == 2'd0) ||
               (reqParity == 2'd1 && !oddIdx) ||
               (reqParity == 2'd2 && oddIdx);
      eligible[u] = inPool && parOk && unitFree[u];
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    unitFound = 1'b0;
    pickUnit  = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--)
      if (eligible[u]) begin
        unitFound = 1'b1;
        pickUnit  = UNIT_W'(u);
      end
    slotFound = 1'b0;
    pickSlot  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (slotFree[s]) begin
        slotFound = 1'b1;
        pickSlot  = SLOT_W'(s);
      end
  end

  always_comb begin
    grant          = reqValid && info.ok && unitFound && slotFound;
    grantUnit      = grant ? pickUnit : '0;
    strobe.load    = grant;
    strobe.unitHot = '0;
    if (grant) strobe.unitHot[pickUnit] = 1'b1;
    strobe.lat     = info.lat;
    strobe.busy    = info.busy;
    slotHot        = '0;
    if (grant) slotHot[pickSlot] = 1'b1;
  end

endmodule

// File: rtl/fu_scb_datapath.sv
module fu_scb_datapath
  import fu_scb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  issueStrobeT                strobe,
  input  logic [NUM_SLOTS-1:0]       slotHot,
  input  logic [TAG_W-1:0]           reqTag,
  output logic [NUM_UNITS-1:0]       unitFree,
  output logic [NUM_SLOTS-1:0]       slotFree,
  output logic [NUM_SLOTS-1:0]       doneMask,
  output logic [NUM_SLOTS*TAG_W-1:0] doneTags
);

  logic [BUSY_W-1:0] busyCnt [NUM_UNITS];
  logic [LAT_W-1:0]  latCnt  [NUM_SLOTS];
  logic [TAG_W-1:0]  slotTag [NUM_SLOTS];

  // per-unit occupancy: issue cycle counts as the first busy cycle
  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    always_ff @(posedge clk) begin
      if (!rstN)                    busyCnt[u] <= '0;
      else if (strobe.unitHot[u])   busyCnt[u] <= strobe.busy - BUSY_W'(1);
      else if (busyCnt[u] != '0)    busyCnt[u] <= busyCnt[u] - BUSY_W'(1);
    end
    assign unitFree[u] = (busyCnt[u] == '0);
  end

  // per-slot latency countdown; count of one marks the result cycle
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        latCnt[s]  <= '0;
        slotTag[s] <= '0;
      end else if (slotHot[s]) begin
        latCnt[s]  <= strobe.lat;
        slotTag[s] <= reqTag;
      end else if (latCnt[s] != '0) begin
        latCnt[s]  <= latCnt[s] - LAT_W'(1);
      end
    end
    assign doneMask[s]                  = (latCnt[s] == LAT_W'(1));
    assign slotFree[s]                  = (latCnt[s] <= LAT_W'(1));
    assign doneTags[s*TAG_W +: TAG_W]   = slotTag[s];
  end

endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
  import fu_scb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [2:0]                 reqPool,
  input  logic [2:0]                 reqOp,
  input  logic [1:0]                 reqParity,
  input  logic [TAG_W-1:0]           reqTag,
  output logic                       reqGrant,
  output logic [UNIT_W-1:0]          grantUnit,
  output logic [NUM_SLOTS-1:0]       doneMask,
  output logic [NUM_SLOTS*TAG_W-1:0] doneTags
);

  issueStrobeT          strobe;
  logic [NUM_SLOTS-1:0] slotHot;
  logic [NUM_UNITS-1:0] unitFree;
  logic [NUM_SLOTS-1:0] slotFree;

  fu_scb_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .reqValid  (reqValid),
    .reqPool   (reqPool),
    .reqOp     (reqOp),
    .reqParity (reqParity),
    .unitFree  (unitFree),
    .slotFree  (slotFree),
    .strobe    (strobe),
    .slotHot   (slotHot),
    .grant     (reqGrant),
    .grantUnit (grantUnit)
  );

  fu_scb_datapath #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotHot  (slotHot),
    .reqTag   (reqTag),
    .unitFree (unitFree),
    .slotFree (slotFree),
    .doneMask (doneMask),
    .doneTags (doneTags)
  );

endmodule

// File: rtl/fu_scoreboard_chk.sv
module fu_scoreboard_chk
  import fu_scb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [2:0]           reqPool,
  input logic [2:0]           reqOp,
  input logic [1:0]           reqParity,
  input logic                 reqGrant,
  input logic [UNIT_W-1:0]    grantUnit,
  input logic [NUM_SLOTS-1:0] doneMask
);

  opInfoT info;
  logic   localOdd;
  logic   inPool;
  int     localIdx;

  always_comb begin
    info     = opLookup(reqPool, reqOp);
    localIdx = int'(grantUnit) - poolBase(reqPool);
    localOdd = (localIdx % 2) != 0;
    inPool   = (localIdx >= 0) && (localIdx < poolCount(reqPool));
  end

  // R8
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> reqValid);

  // R8
  bad_class_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !info.ok) |-> !reqGrant);

  // R6
  even_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && reqParity == 2'd1) |-> !localOdd);

  // R6
  odd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && reqParity == 2'd2) |-> localOdd);

  // R5
  unit_in_pool_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> inPool);

  // R4
  unit_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && info.busy > BUSY_W'(1)) |=> !(reqGrant && grantUnit == $past(grantUnit)));

  // R3
  store_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && reqPool == 3'd4 && reqOp == 3'd0) |=> (doneMask != '0));

endmodule

bind fu_scoreboard fu_scoreboard_chk #(.NUM_SLOTS(NUM_SLOTS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqPool   (reqPool),
  .reqOp     (reqOp),
  .reqParity (reqParity),
  .reqGrant  (reqGrant),
  .grantUnit (grantUnit),
  .doneMask  (doneMask)
);

// File: tb/sim_fu_scoreboard.sv
module sim_fu_scoreboard;
  import fu_scb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;
  localparam int TW         = 8;
  localparam int WATCHDOG   = 5000;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0;
  logic [2:0]            reqPool = '0;
  logic [2:0]            reqOp = '0;
  logic [1:0]            reqParity = '0;
  logic [TW-1:0]         reqTag = '0;
  logic                  reqGrant;
  logic [UNIT_W-1:0]     grantUnit;
  logic [SLOTS-1:0]      doneMask;
  logic [SLOTS*TW-1:0]   doneTags;

  fu_scoreboard #(.NUM_SLOTS(SLOTS), .TAG_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPool(reqPool), .reqOp(reqOp),
    .reqParity(reqParity), .reqTag(reqTag), .reqGrant(reqGrant), .grantUnit(grantUnit),
    .doneMask(doneMask), .doneTags(doneTags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int nextTag = 1;
  bit finished = 1'b0;

  typedef struct {
    int    tag;
    int    due;
    int    slot;
    string req;
  } expT;
  expT pend[$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: present one request for one cycle and push the expected result
  task automatic issue(input int pool, input int op, input int par, input bit expG,
                       input int expU, input int expLat, input int expSlot, input string req);
    @(negedge clk);
    reqValid  = 1'b1;
    reqPool   = 3'(pool);
    reqOp     = 3'(op);
    reqParity = 2'(par);
    reqTag    = TW'(nextTag);
    #(CLK_PERIOD/4);
    check(reqGrant == expG, req, "grant", int'(reqGrant), int'(expG));
    if (expG) begin
      check(int'(grantUnit) == expU, req, "unit", int'(grantUnit), expU);
      pend.push_back('{nextTag, cyc + expLat, expSlot, req});
    end
    nextTag = (nextTag % 255) + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor: every result pulse must match a pending item due this cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (doneMask[s]) begin
          int t;
          int idx;
          t = int'(doneTags[s*TW +: TW]);
          idx = -1;
          for (int i = 0; i < pend.size(); i++)
            if (pend[i].tag == t) idx = i;
          if (idx < 0) begin
            check(1'b0, "R3 or R8", "unexpected result tag", t, -1);
          end else begin
            check(pend[idx].due == cyc, pend[idx].req, "result cycle", cyc, pend[idx].due);
            if (pend[idx].slot >= 0)
              check(pend[idx].slot == s, "R10", "result slot", s, pend[idx].slot);
            pend.delete(idx);
          end
        end
      end
      for (int i = pend.size() - 1; i >= 0; i--)
        if (pend[i].due < cyc) begin
          check(1'b0, pend[i].req, "missing result", cyc, pend[i].due);
          pend.delete(i);
        end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    // R1
    check(doneMask == '0, "R1", "doneMask after reset", int'(doneMask), 0);
    check(reqGrant == 1'b0, "R1", "grant idle", int'(reqGrant), 0);

    // ALU: busy one cycle, latency 2/3, cracked 4/6, parity
    issue(0, 0, 0, 1, 0, 2, -1, "R9 alu lat2");
    issue(0, 1, 0, 1, 0, 3, -1, "R4 alu reuse next cycle");
    issue(0, 2, 0, 1, 0, 4, -1, "R7 alu cracked 4");
    issue(0, 3, 2, 1, 1, 6, -1, "R6 alu odd");
    issue(0, 3, 1, 1, 0, 6, -1, "R6 alu even");
    idle(10);

    // load/store, branch, crypto, permute, invalid class, bad parity
    issue(4, 0, 0, 1, 11, 1, -1, "R3 store lat1");
    issue(4, 1, 0, 1, 11, 4, -1, "R9 load lat4");
    issue(4, 4, 0, 1, 11, 6, -1, "R7 load+alu 6");
    issue(4, 6, 0, 1, 11, 8, -1, "R7 load+load 8");
    issue(6, 2, 0, 1, 17, 7, -1, "R7 branch+alu 7");
    issue(7, 0, 0, 1, 18, 6, -1, "R2 crypto unit");
    issue(5, 0, 0, 1, 15, 3, -1, "R2 permute unit");
    issue(5, 3, 0, 0, 0, 0, -1, "R8 undefined permute class");
    issue(0, 0, 3, 0, 0, 0, -1, "R6 parity code 3");
    issue(3, 7, 0, 0, 0, 0, -1, "R8 undefined decimal class");
    idle(12);

    // divide: occupancy 8 shorter than latency 16
    issue(1, 2, 0, 1, 4, 16, -1, "R9 div 16/8");
    issue(1, 5, 0, 1, 5, 18, -1, "R7 div+alu 18");
    issue(1, 0, 0, 0, 0, 0, -1, "R8 both dividers busy");
    idle(4);
    issue(1, 0, 0, 0, 0, 0, -1, "R4 divider still busy");
    issue(1, 0, 0, 1, 4, 5, -1, "R4 divider free at c+8");
    idle(30);

    // floating point with parity and lowest-free selection
    issue(2, 5, 1, 1, 6, 36, -1, "R5 fp even first");
    issue(2, 5, 1, 1, 8, 36, -1, "R6 fp next even");
    issue(2, 5, 1, 0, 0, 0, -1, "R6 no even fp free");
    issue(2, 5, 2, 1, 7, 36, -1, "R6 fp odd");
    issue(2, 0, 0, 1, 9, 5, -1, "R5 fp last free");
    issue(2, 0, 0, 1, 9, 5, -1, "R4 fp busy1 reuse");
    idle(40);

    // decimal: single even unit, 62-cycle occupancy boundary
    issue(3, 5, 2, 0, 0, 0, -1, "R6 no odd decimal unit");
    issue(3, 5, 0, 1, 10, 76, -1, "R9 decimal 76/62");
    idle(60);
    issue(3, 0, 0, 0, 0, 0, -1, "R4 decimal busy at c+61");
    issue(3, 0, 0, 1, 10, 12, -1, "R4 decimal free at c+62");
    idle(90);

    // tracking slot exhaustion and same-cycle reuse
    issue(2, 5, 0, 1, 6, 36, 0, "R10 slot 0");
    issue(2, 5, 0, 1, 7, 36, 1, "R10 slot 1");
    issue(2, 5, 0, 1, 8, 36, 2, "R10 slot 2");
    issue(2, 5, 0, 1, 9, 36, 3, "R10 slot 3");
    issue(1, 4, 0, 1, 4, 40, 4, "R10 slot 4");
    issue(1, 4, 0, 1, 5, 40, 5, "R10 slot 5");
    issue(3, 5, 0, 1, 10, 76, 6, "R10 slot 6");
    issue(4, 1, 0, 1, 11, 4, 7, "R10 slot 7");
    issue(4, 1, 0, 0, 0, 0, -1, "R10 slots full");
    idle(2);
    issue(4, 1, 0, 1, 11, 4, 7, "R10 slot reuse on pulse cycle");
    idle(100);

    check(pend.size() == 0, "R3", "pending results left", pend.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule